// File: doc/BRIEF.md
# Clock Synthesizer Parameter Register Set

This block holds the loop settings for a small bank of frequency synthesizers. Each synthesizer owns a group of four byte-wide registers. The first register holds the feedback multiplier M, stored as M minus 2. The second holds the reference divider N, stored as N minus 2. The third has no function. The fourth is a control byte. It carries the post-divide exponent, the loop-divide choice and the source select.

Software writes a group by stepping through its four indices in ascending order. The group's active values change only on the final, fourth write. A partial, reordered or interleaved sequence leaves the active settings untouched.

The block decodes the active values for every group into effective M and N, a loop-divide factor and a post-divide exponent. It also gives a frequency ratio as numerator and denominator, so that f_out = f_ref * num / den. One group may also drive a built-in power-of-two divider, which emits a strobe every 2^k cycles of the block clock.

Top module: `clksyn_regs`

## Requirements
- R1: After reset every group reads back 0x00 at all four indices. Each group presents M=2, N=2, post exponent 0, source select 0 and error flag 0. Every group except the memory group presents loop-divide LD_CLR. The register index is {group, reg}, with reg in bits 1:0.
- R2: Writing reg 0, 1, 2 and 3 of one group in that order commits the group on the clock edge of the reg-3 write. From the next cycle, reg 0 and reg 1 read back the bytes last written, and M and N equal those bytes plus 2.
- R3: Until a sequence is complete, the active values and read-back data of a group stay unchanged. This holds after writes to reg 0 to 2 only, and after a lone reg-3 write.
- R4: A write to a register other than the next expected one aborts the sequence; a reg-3 write that skips reg 2 does not commit. A reg-0 write always restarts the sequence, with that byte staged as the new M.
- R5: Any write to a different group aborts the sequence in progress in the group being written.
- R6: Control byte bits 6:4 give the post-divide exponent k (0 to 5). The ratio denominator equals N * 2^k.
- R7: Codes 6 and 7 in bits 6:4 are reserved. A sequence that ends with a reserved code commits nothing and sets that group's error flag. The next valid commit of the group clears the flag.
- R8: In a group other than the memory group, control bit 2 set selects loop-divide LD_SET (1) and bit 2 clear selects LD_CLR (4). The ratio numerator equals M times the loop-divide factor.
- R9: The memory group (MEM_SET) has no loop-divide field. Its factor is always 1, and its bit 2 reads back 0.
- R10: Control bit 7 is output as the group's source select and reads back as written.
- R11: Reg 2 always reads 0x00. Control bits 3, 1 and 0 always read back 0.
- R12: When the divider group DIV_SET commits exponent k, the divider restarts. div_stb is high for one cycle out of every 2^k, first in the (2^k)-th cycle after the commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Write index {group, reg} |
| wr_data | input | 8 | Write data |
| rd_idx | input | IDX_W | Read index {group, reg} |
| rd_data | output | 8 | Committed value at rd_idx (combinational) |
| m_eff | output | NSETS*9 | Effective M per group |
| n_eff | output | NSETS*9 | Effective N per group |
| ld_eff | output | NSETS*3 | Loop-divide factor per group |
| pd_log | output | NSETS*3 | Post-divide exponent per group |
| vco_sel | output | NSETS | Source select per group |
| cfg_err | output | NSETS | Reserved-code error flag per group |
| ratio_num | output | NSETS*12 | Ratio numerator (loop-divide * M) |
| ratio_den | output | NSETS*14 | Ratio denominator (N * 2^k) |
| div_stb | output | 1 | Post-divider strobe for group DIV_SET |

## Verification
Two events can fall on the same clock edge: a commit of the divider group, and the divider's own strobe or a read-back of that group. The bench holds rd_idx on the group while the fourth write lands. It expects the old bytes before that edge and the new bytes straight after it. It then times the divider from the commit edge, checking both the position of the first strobe and the number of strobes in a 64-cycle window for every legal exponent. A strobe left over from the previous exponent would shift both figures.

// File: rtl/clksyn_regs.sv
module clksyn_regs #(
  parameter int NSETS   = 4,
  parameter int MEM_SET = NSETS - 1,
  parameter int DIV_SET = 0,
  parameter int HAS_DIV = 1,
  parameter int LD_SET  = 1,
  parameter int LD_CLR  = 4,
  localparam int SET_W  = (NSETS > 1) ? $clog2(NSETS) : 1,
  localparam int IDX_W  = SET_W + 2,
  localparam int MN_W   = 9,
  localparam int LD_W   = 3,
  localparam int PD_W   = 3,
  localparam int NUM_W  = MN_W + LD_W,
  localparam int DEN_W  = MN_W + 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [7:0]             wr_data,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [7:0]             rd_data,
  output logic [NSETS*MN_W-1:0]  m_eff,
  output logic [NSETS*MN_W-1:0]  n_eff,
  output logic [NSETS*LD_W-1:0]  ld_eff,
  output logic [NSETS*PD_W-1:0]  pd_log,
  output logic [NSETS-1:0]       vco_sel,
  output logic [NSETS-1:0]       cfg_err,
  output logic [NSETS*NUM_W-1:0] ratio_num,
  output logic [NSETS*DEN_W-1:0] ratio_den,
  output logic                   div_stb
);

  logic [7:0] c_m   [NSETS];
  logic [7:0] c_n   [NSETS];
  logic [7:0] c_sel [NSETS];
  logic [1:0] trk   [NSETS];
  logic [7:0] st_m, st_n;

  logic [SET_W-1:0] wr_set, rd_set;
  logic [1:0]       wr_reg, rd_reg;
  logic             wr_ok, seq_hit, rsv, commit, rsv_hit;
  logic [7:0]       sel_mask;

  assign wr_set   = wr_idx[IDX_W-1:2];
  assign wr_reg   = wr_idx[1:0];
  assign rd_set   = rd_idx[IDX_W-1:2];
  assign rd_reg   = rd_idx[1:0];
  assign wr_ok    = wr_en && ({1'b0, wr_set} < (SET_W+1)'(NSETS));
  assign seq_hit  = wr_ok && (wr_reg == trk[wr_set]);
  assign rsv      = (wr_data[6:5] == 2'b11);
  assign commit   = seq_hit && (wr_reg == 2'd3) && !rsv;
  assign rsv_hit  = seq_hit && (wr_reg == 2'd3) && rsv;
  assign sel_mask = (int'(wr_set) == MEM_SET) ? 8'hF0 : 8'hF4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) begin
        c_m[s]   <= '0;
        c_n[s]   <= '0;
        c_sel[s] <= '0;
        trk[s]   <= '0;
      end
      st_m    <= '0;
      st_n    <= '0;
      cfg_err <= '0;
    end else if (wr_ok) begin
      for (int s = 0; s < NSETS; s++)
        if (SET_W'(s) != wr_set) trk[s] <= '0;
      if (seq_hit) begin
        if (wr_reg == 2'd0) st_m <= wr_data;
        if (wr_reg == 2'd1) st_n <= wr_data;
        trk[wr_set] <= wr_reg + 2'd1;
        if (commit) begin
          c_m[wr_set]     <= st_m;
          c_n[wr_set]     <= st_n;
          c_sel[wr_set]   <= wr_data & sel_mask;
          cfg_err[wr_set] <= 1'b0;
        end
        if (rsv_hit) cfg_err[wr_set] <= 1'b1;
      end else if (wr_reg == 2'd0) begin
        st_m        <= wr_data;
        trk[wr_set] <= 2'd1;
      end else begin
        trk[wr_set] <= 2'd0;
      end
    end
  end

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic [MN_W-1:0] m_v, n_v;
    logic [LD_W-1:0] ld_v;
    logic [PD_W-1:0] pd_v;
    assign m_v  = {1'b0, c_m[s]} + MN_W'(2);
    assign n_v  = {1'b0, c_n[s]} + MN_W'(2);
    assign pd_v = c_sel[s][6:4];
    if (s == MEM_SET) begin : g_mem
      assign ld_v = LD_W'(1);
    end else begin : g_dot
      assign ld_v = c_sel[s][2] ? LD_W'(LD_SET) : LD_W'(LD_CLR);
    end
    assign m_eff[s*MN_W +: MN_W]      = m_v;
    assign n_eff[s*MN_W +: MN_W]      = n_v;
    assign ld_eff[s*LD_W +: LD_W]     = ld_v;
    assign pd_log[s*PD_W +: PD_W]     = pd_v;
    assign vco_sel[s]                 = c_sel[s][7];
    assign ratio_num[s*NUM_W +: NUM_W] = NUM_W'(m_v) * NUM_W'(ld_v);
    assign ratio_den[s*DEN_W +: DEN_W] = DEN_W'(n_v) << pd_v;
  end

  always_comb begin
    rd_data = 8'h00;
    if ({1'b0, rd_set} < (SET_W+1)'(NSETS)) begin
      case (rd_reg)
        2'd0:    rd_data = c_m[rd_set];
        2'd1:    rd_data = c_n[rd_set];
        2'd3:    rd_data = c_sel[rd_set];
        default: rd_data = 8'h00;
      endcase
    end
  end

  if (HAS_DIV != 0) begin : g_div
    logic [4:0] cnt, lim;
    logic [PD_W-1:0] pd_d;
    assign pd_d    = c_sel[DIV_SET][6:4];
    assign lim     = 5'((6'd1 << pd_d) - 6'd1);
    assign div_stb = (cnt == lim);
    always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (commit && int'(wr_set) == DIV_SET) cnt <= '0;
      else if (div_stb) cnt <= '0;
      else cnt <= cnt + 5'd1;
    end
  end else begin : g_nodiv
    assign div_stb = 1'b0;
  end

endmodule

// File: rtl/clksyn_regs_chk.sv
module clksyn_regs_chk #(
  parameter int NSETS   = 4,
  parameter int MEM_SET = NSETS - 1,
  parameter int DIV_SET = 0,
  parameter int IDX_W   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [1:0]            wr_reg,
  input logic [IDX_W-1:0]      rd_idx,
  input logic [7:0]            rd_data,
  input logic [NSETS*9-1:0]    m_eff,
  input logic [NSETS*3-1:0]    pd_log,
  input logic [NSETS-1:0]      cfg_err,
  input logic                  div_stb
);
  localparam logic [IDX_W-1:0] MEM_CTL = IDX_W'(MEM_SET * 4 + 3);
  logic [2:0] pd_div;
  assign pd_div = pd_log[DIV_SET*3 +: 3];

  a_r2_commit_on_last_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(m_eff) |-> ($past(wr_en) && $past(wr_reg) == 2'd3));

  a_r3_readback_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_idx) && !$past(wr_en)) |-> $stable(rd_data));

  a_r7_reserved_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    |(cfg_err & ~$past(cfg_err)) |-> ($stable(m_eff) && $stable(pd_log)));

  a_r9_mem_no_loop_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == MEM_CTL) |-> (rd_data[2] == 1'b0));

  a_r11_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx[1:0] == 2'd3) |-> (rd_data[3] == 1'b0 && rd_data[1:0] == 2'b00));

  a_r12_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (div_stb && $past(div_stb) && $stable(pd_div)) |-> (pd_div == 3'd0));
endmodule

bind clksyn_regs clksyn_regs_chk #(
  .NSETS(NSETS), .MEM_SET(MEM_SET), .DIV_SET(DIV_SET), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_idx[1:0]),
  .rd_idx(rd_idx), .rd_data(rd_data), .m_eff(m_eff), .pd_log(pd_log),
  .cfg_err(cfg_err), .div_stb(div_stb)
);

// File: tb/clksyn_regs_bench.sv
`timescale 1ns/1ps
module clksyn_regs_bench;
  localparam int NS = 4, MEM = 3, DIVS = 0;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_idx = '0, rd_idx = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [NS*9-1:0] m_eff, n_eff;
  logic [NS*3-1:0] ld_eff, pd_log;
  logic [NS-1:0] vco_sel, cfg_err;
  logic [NS*12-1:0] ratio_num;
  logic [NS*14-1:0] ratio_den;
  logic div_stb;

  int checks = 0, errors = 0;
  int exp_m [NS], exp_n [NS], exp_sel [NS], exp_err [NS];

  always #2 clk = ~clk;

  clksyn_regs #(.NSETS(NS), .MEM_SET(MEM), .DIV_SET(DIVS)) u_clksyn_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .m_eff(m_eff), .n_eff(n_eff),
    .ld_eff(ld_eff), .pd_log(pd_log), .vco_sel(vco_sel), .cfg_err(cfg_err),
    .ratio_num(ratio_num), .ratio_den(ratio_den), .div_stb(div_stb));

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input int s, input int r, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(s * 4 + r); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic full_seq(input int s, input int m, input int n, input int sel);
    wr(s, 0, m); wr(s, 1, n); wr(s, 2, 8'hAA); wr(s, 3, sel);
    if (((sel >> 5) & 3) == 3) exp_err[s] = 1;
    else begin
      exp_m[s] = m; exp_n[s] = n; exp_err[s] = 0;
      exp_sel[s] = sel & ((s == MEM) ? 8'hF0 : 8'hF4);
    end
  endtask

  task automatic check_set(input string req, input int s);
    int ld, pd;
    pd = (exp_sel[s] >> 4) & 7;
    ld = (s == MEM) ? 1 : (((exp_sel[s] >> 2) & 1) != 0 ? 1 : 4);
    rd_idx = 4'(s * 4 + 0); #1; chk({req, " R2 rd m"}, rd_data, exp_m[s]);
    rd_idx = 4'(s * 4 + 1); #1; chk({req, " R2 rd n"}, rd_data, exp_n[s]);
    rd_idx = 4'(s * 4 + 2); #1; chk({req, " R11 rd spare"}, rd_data, 0);
    rd_idx = 4'(s * 4 + 3); #1; chk({req, " R10 rd ctl"}, rd_data, exp_sel[s]);
    chk({req, " R2 m_eff"}, m_eff[s*9 +: 9], exp_m[s] + 2);
    chk({req, " R2 n_eff"}, n_eff[s*9 +: 9], exp_n[s] + 2);
    chk({req, " R8 ld"}, ld_eff[s*3 +: 3], ld);
    chk({req, " R6 pd"}, pd_log[s*3 +: 3], pd);
    chk({req, " R10 vco"}, vco_sel[s], (exp_sel[s] >> 7) & 1);
    chk({req, " R7 err"}, cfg_err[s], exp_err[s]);
    chk({req, " R8 num"}, ratio_num[s*12 +: 12], (exp_m[s] + 2) * ld);
    chk({req, " R6 den"}, ratio_den[s*14 +: 14], (exp_n[s] + 2) << pd);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      exp_m[s] = 0; exp_n[s] = 0; exp_sel[s] = 0; exp_err[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < NS; s++) check_set("R1 reset", s);

    // R2 R6 R7 R8 R9 R10 R11: sweep every group, control code and loop bit
    for (int s = 0; s < NS; s++)
      for (int b2 = 0; b2 < 2; b2++)
        for (int code = 0; code < 8; code++) begin
          int m, n, sel;
          m = (s * 37 + code * 11 + b2 * 5 + 3) & 255;
          n = (s * 13 + code * 29 + b2 * 7 + 1) & 255;
          sel = (((code ^ b2) & 1) << 7) | (code << 4) | (b2 << 2) | 8'h0B;
          full_seq(s, m, n, sel);
          check_set("sweep", s);
        end

    // R3 R5: partial sequence, then interleaved group, then lone reg 3
    full_seq(1, 8'h40, 8'h05, 8'h30);
    wr(1, 0, 8'h11); wr(1, 1, 8'h22); wr(1, 2, 8'h00);
    check_set("R3 partial", 1);
    wr(2, 0, 8'h77);
    wr(1, 3, 8'h10);
    check_set("R5 interleave", 1);
    wr(3, 3, 8'h20);
    check_set("R3 lone reg3", 3);

    // R4: skipped reg 2, then restart via reg 0 mid-sequence
    full_seq(0, 8'h20, 8'h03, 8'h10);
    wr(0, 0, 8'h55); wr(0, 1, 8'h66); wr(0, 3, 8'h20);
    check_set("R4 skip", 0);
    wr(0, 0, 8'h01); wr(0, 1, 8'h02); wr(0, 0, 8'h7D); wr(0, 1, 8'h07);
    wr(0, 2, 8'h00); wr(0, 3, 8'h34);
    exp_m[0] = 8'h7D; exp_n[0] = 8'h07; exp_sel[0] = 8'h34; exp_err[0] = 0;
    check_set("R4 restart", 0);

    // R12: read-back and divider around the commit edge of the divider group
    for (int k = 0; k < 6; k++) begin
      int first, cnt;
      int prev_m;
      prev_m = exp_m[DIVS];
      rd_idx = 4'(DIVS * 4);
      wr(DIVS, 0, k + 9); wr(DIVS, 1, 4); wr(DIVS, 2, 0);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'(DIVS * 4 + 3); wr_data = 8'(k << 4);
      #1 chk("R3 read before commit edge", rd_data, prev_m);
      @(negedge clk);
      wr_en = 1'b0;
      exp_m[DIVS] = k + 9; exp_n[DIVS] = 4; exp_sel[DIVS] = k << 4;
      rd_idx = 4'(DIVS * 4);
      #1 chk("R2 read after commit edge", rd_data, k + 9);
      first = -1; cnt = 0;
      for (int i = 0; i < 64; i++) begin
        if (i > 0) @(negedge clk);
        if (div_stb) begin
          cnt++;
          if (first < 0) first = i;
        end
      end
      chk("R12 first strobe", first, (1 << k) - 1);
      chk("R12 strobe count", cnt, 64 >> k);
    end
    check_set("R12 final", DIVS);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule